// File: doc/BRIEF.md
# Weighted Virtual Channel Arbiter

This block decides which virtual channel (VC) may begin the next packet on an outbound link. Each cycle it looks at per-channel request and enable bits. It also uses two configuration counts: how many channels exist beyond channel 0, and how many of them join channel 0 in the low-priority group. When the link signals that a packet may start, the block registers a one-hot grant that lasts one cycle.

Channels above the low-priority group are served by strict priority, and the highest channel number wins. Channels inside the group share the link in one of two ways. The first is plain round robin. The second is weighted round robin, driven by a phase table of 32 or 64 phases. Each table entry names the channel that owns that phase.

Software writes the phase table into a pending copy. A load strobe then moves the pending copy into the active copy, one entry per cycle, and a busy status shows while that copy runs. The scheme select is frozen while more than one channel of the low-priority group is enabled.

Top module: `wvc_arbiter`

## Requirements
- R1: After synchronous reset, `gnt` is 0, `tbl_busy` is 0, the group scheme is round robin, the round-robin search starts at VC0, and every active phase entry holds 0, which names VC0.
- R2: In the cycle after a cycle with `pkt_start`=1, `gnt` is one-hot when at least one channel with id <= `ext_cnt` has both its request and enable bits set. Otherwise `gnt` is 0 in that cycle. A channel with id > `ext_cnt` is never granted.
- R3: A channel with id > `lp_cnt` that is eligible always beats the low-priority group. Among such channels, the highest id is granted.
- R4: In round-robin mode, the group is channels 0..`lp_cnt`. The search starts just after the last group channel granted, moves in ascending id order and wraps around.
- R5: `sched_sel` code 0 selects round robin, code 1 selects weighted with 32 phases, code 2 selects weighted with 64 phases, and codes 3 to 7 select round robin. An accepted change takes effect from the next cycle and returns the phase pointer to phase 0.
- R6: A change of `sched_sel` has no effect while more than one group channel is enabled.
- R7: In weighted mode, the scan starts at the phase pointer and grants the first phase whose entry names an eligible group channel. Within the same cycle it skips entries that are 8 or more, entries that name a channel outside the group, and entries that name an ineligible channel. After such a grant the pointer moves to the phase after the granted one and wraps at the phase count. The pointer is unchanged when no group grant is made.
- R8: Table writes (`tbl_wr_en`, `tbl_wr_addr` = phase, `tbl_wr_data` = 4-bit channel id) only change the pending copy, and the grants do not change until a load.
- R9: After a cycle with `tbl_load`=1, `tbl_busy` reads 1 and the pending table is copied into the active table. `tbl_busy` returns to 0 exactly 66 cycles after the strobe (PHASES+2). A load during a copy restarts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_cnt | input | 3 | Highest existing channel id |
| lp_cnt | input | 3 | Highest channel id in the low-priority group |
| sched_sel | input | 3 | Requested group scheme code |
| vc_en | input | 8 | Per-channel enable |
| vc_req | input | 8 | Per-channel request |
| pkt_start | input | 1 | Link may start a packet this cycle |
| tbl_wr_en | input | 1 | Write one pending phase entry |
| tbl_wr_addr | input | 6 | Phase index to write |
| tbl_wr_data | input | 4 | Channel id owning the phase |
| tbl_load | input | 1 | Copy pending table into active table |
| tbl_busy | output | 1 | Active table copy in progress |
| gnt | output | 8 | One-hot registered grant |

## Verification
The bench makes upper channels compete against group requests. A design that let the group win, or that picked the lowest upper channel, would show the wrong grant bit. A round-robin stream is checked across the group wrap. A design that did not skip non-group channels would stall or grant out of range.

In weighted mode the table has holes, and it places a channel only in phases 32 to 63. A design that did not skip in the same cycle, or that wrapped at the wrong phase count, grants the wrong channel or grants one that is out of reach. The frozen select and the load timing are also checked. A design that accepted the select under lock, showed table writes before a load, or did not restart a copy on a second load gives grants or busy values that differ from the expected ones.

// File: rtl/wvc_pkg.sv
package wvc_pkg;
  typedef enum logic [1:0] {
    SCH_RR  = 2'd0,
    SCH_W32 = 2'd1,
    SCH_W64 = 2'd2
  } sched_e;

  function automatic sched_e decode_sched(input logic [2:0] code);
    case (code)
      3'd1:    return SCH_W32;
      3'd2:    return SCH_W64;
      default: return SCH_RR;
    endcase
  endfunction
endpackage

// File: rtl/wvc_phase_table.sv
module wvc_phase_table #(
  parameter int PHASES  = 64,
  parameter int ENTRY_W = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [$clog2(PHASES)-1:0]        wr_addr,
  input  logic [ENTRY_W-1:0]               wr_data,
  input  logic                             load,
  output logic                             busy,
  output logic [PHASES-1:0][ENTRY_W-1:0]   act_tbl
);
  localparam int PH_W = $clog2(PHASES);
  localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

  // pending copy: one write port, one synchronous read port (RAM style)
  logic [ENTRY_W-1:0] pend_mem [PHASES];
  logic [ENTRY_W-1:0] rd_q;
  logic [PH_W-1:0]    cp_ra, cp_wa;
  logic               cp_iss, cp_wv;

  always_ff @(posedge clk) begin
    if (wr_en) pend_mem[wr_addr] <= wr_data;
    rd_q <= pend_mem[cp_ra];
  end

  // sequential copier: issue reads, write active one cycle later
  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cp_ra  <= '0;
      cp_wa  <= '0;
      cp_iss <= 1'b0;
      cp_wv  <= 1'b0;
    end else if (load) begin
      busy   <= 1'b1;
      cp_ra  <= '0;
      cp_iss <= 1'b1;
      cp_wv  <= 1'b0;
    end else if (busy) begin
      cp_wv <= cp_iss;
      cp_wa <= cp_ra;
      if (cp_iss) begin
        if (cp_ra == LAST) cp_iss <= 1'b0;
        else               cp_ra  <= cp_ra + PH_W'(1);
      end
      if (cp_wv && cp_wa == LAST) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < PHASES; p++) act_tbl[p] <= '0;
    end else if (busy && cp_wv && !load) begin
      act_tbl[cp_wa] <= rd_q;
    end
  end

  assert_load_sets_busy_R9: assert property (@(posedge clk) disable iff (rst)
    load |=> busy);
endmodule

// File: rtl/wvc_sp_pick.sv
module wvc_sp_pick #(
  parameter int NUM_VC = 8
) (
  input  logic [NUM_VC-1:0]         cand,
  output logic                      hit,
  output logic [$clog2(NUM_VC)-1:0] vc
);
  localparam int VC_W = $clog2(NUM_VC);

  // highest set index wins
  always_comb begin
    hit = 1'b0;
    vc  = '0;
    for (int i = 0; i < NUM_VC; i++) begin
      if (cand[i]) begin
        hit = 1'b1;
        vc  = VC_W'(i);
      end
    end
  end
endmodule

// File: rtl/wvc_lp_pick.sv
module wvc_lp_pick
  import wvc_pkg::*;
#(
  parameter int NUM_VC  = 8,
  parameter int PHASES  = 64,
  parameter int ENTRY_W = 4
) (
  input  sched_e                           mode,
  input  logic [NUM_VC-1:0]                elig,
  input  logic [$clog2(NUM_VC)-1:0]        rr_last,
  input  logic [$clog2(PHASES)-1:0]        ph_ptr,
  input  logic [PHASES-1:0][ENTRY_W-1:0]   act_tbl,
  output logic                             hit,
  output logic [$clog2(NUM_VC)-1:0]        vc,
  output logic [$clog2(PHASES)-1:0]        ph_next
);
  localparam int VC_W = $clog2(NUM_VC);
  localparam int PH_W = $clog2(PHASES);

  always_comb begin
    int               id;
    logic [VC_W-1:0]  cvc;
    logic [PH_W-1:0]  mask;
    logic [PH_W-1:0]  idx;
    logic [ENTRY_W-1:0] own;
    id      = 0;
    cvc     = '0;
    idx     = '0;
    own     = '0;
    mask    = (mode == SCH_W32) ? PH_W'(PHASES/2 - 1) : PH_W'(PHASES - 1);
    hit     = 1'b0;
    vc      = '0;
    ph_next = ph_ptr;
    if (mode == SCH_RR) begin
      for (int k = 1; k <= NUM_VC; k++) begin
        id  = (int'(rr_last) + k) % NUM_VC;
        cvc = VC_W'(id);
        if (!hit && elig[cvc]) begin
          hit = 1'b1;
          vc  = cvc;
        end
      end
    end else begin
      for (int k = 0; k < PHASES; k++) begin
        idx = (ph_ptr + PH_W'(k)) & mask;
        own = act_tbl[idx];
        cvc = own[VC_W-1:0];
        if (!hit && (int'(own) < NUM_VC) && elig[cvc]) begin
          hit     = 1'b1;
          vc      = cvc;
          ph_next = (idx + PH_W'(1)) & mask;
        end
      end
    end
  end
endmodule

// File: rtl/wvc_arbiter.sv
module wvc_arbiter
  import wvc_pkg::*;
#(
  parameter int NUM_VC  = 8,
  parameter int PHASES  = 64,
  parameter int ENTRY_W = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [$clog2(NUM_VC)-1:0]   ext_cnt,
  input  logic [$clog2(NUM_VC)-1:0]   lp_cnt,
  input  logic [2:0]                  sched_sel,
  input  logic [NUM_VC-1:0]           vc_en,
  input  logic [NUM_VC-1:0]           vc_req,
  input  logic                        pkt_start,
  input  logic                        tbl_wr_en,
  input  logic [$clog2(PHASES)-1:0]   tbl_wr_addr,
  input  logic [ENTRY_W-1:0]          tbl_wr_data,
  input  logic                        tbl_load,
  output logic                        tbl_busy,
  output logic [NUM_VC-1:0]           gnt
);
  localparam int VC_W = $clog2(NUM_VC);
  localparam int PH_W = $clog2(PHASES);

  logic [NUM_VC-1:0] exist_mask, lp_mask, elig, upper, lp_elig;
  logic [PHASES-1:0][ENTRY_W-1:0] act_tbl;
  sched_e          sched_q, sched_new;
  logic            sched_lock;
  logic [VC_W-1:0] rr_last, sp_vc, lp_vc;
  logic [PH_W-1:0] ph_ptr, ph_next;
  logic            sp_hit, lp_hit;

  always_comb begin
    for (int i = 0; i < NUM_VC; i++) begin
      exist_mask[i] = (i <= int'(ext_cnt));
      lp_mask[i]    = exist_mask[i] && (i <= int'(lp_cnt));
    end
  end

  assign elig       = vc_req & vc_en & exist_mask;
  assign upper      = elig & ~lp_mask;
  assign lp_elig    = elig & lp_mask;
  assign sched_lock = ($countones(vc_en & lp_mask) > 1);
  assign sched_new  = decode_sched(sched_sel);

  wvc_phase_table #(.PHASES(PHASES), .ENTRY_W(ENTRY_W)) u_tbl (
    .clk(clk), .rst(rst), .wr_en(tbl_wr_en), .wr_addr(tbl_wr_addr),
    .wr_data(tbl_wr_data), .load(tbl_load), .busy(tbl_busy), .act_tbl(act_tbl)
  );

  wvc_sp_pick #(.NUM_VC(NUM_VC)) u_sp (
    .cand(upper), .hit(sp_hit), .vc(sp_vc)
  );

  wvc_lp_pick #(.NUM_VC(NUM_VC), .PHASES(PHASES), .ENTRY_W(ENTRY_W)) u_lp (
    .mode(sched_q), .elig(lp_elig), .rr_last(rr_last), .ph_ptr(ph_ptr),
    .act_tbl(act_tbl), .hit(lp_hit), .vc(lp_vc), .ph_next(ph_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt     <= '0;
      sched_q <= SCH_RR;
      ph_ptr  <= '0;
      rr_last <= VC_W'(NUM_VC - 1);
    end else begin
      gnt <= '0;
      if (pkt_start) begin
        if (sp_hit) begin
          gnt <= NUM_VC'(1) << sp_vc;
        end else if (lp_hit) begin
          gnt <= NUM_VC'(1) << lp_vc;
          if (sched_q == SCH_RR) rr_last <= lp_vc;
          else                   ph_ptr  <= ph_next;
        end
      end
      if (!sched_lock && sched_new != sched_q) begin
        sched_q <= sched_new;
        ph_ptr  <= '0;
      end
    end
  end

  assert_gnt_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  assert_gnt_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
    (gnt != '0) |-> ($past(pkt_start) && ((gnt & $past(elig)) != '0)));

  assert_upper_beats_group_R3: assert property (@(posedge clk) disable iff (rst)
    (pkt_start && (upper != '0)) |=> ((gnt != '0) && ((gnt & $past(lp_mask)) == '0)));

  assert_sched_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    sched_lock |=> $stable(sched_q));
endmodule

// File: tb/wvc_arbiter_test.sv
module wvc_arbiter_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] ext_cnt, lp_cnt, sched_sel;
  logic [7:0] vc_en, vc_req;
  logic       pkt_start, tbl_wr_en, tbl_load;
  logic [5:0] tbl_wr_addr;
  logic [3:0] tbl_wr_data;
  logic       tbl_busy;
  logic [7:0] gnt;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  wvc_arbiter uut (
    .clk(clk), .rst(rst), .ext_cnt(ext_cnt), .lp_cnt(lp_cnt), .sched_sel(sched_sel),
    .vc_en(vc_en), .vc_req(vc_req), .pkt_start(pkt_start), .tbl_wr_en(tbl_wr_en),
    .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data), .tbl_load(tbl_load),
    .tbl_busy(tbl_busy), .gnt(gnt)
  );

  // {req[7:0], pkt_start, expected gnt[7:0]}; group = VC0..VC3, round robin
  localparam logic [16:0] VECS [14] = '{
    {8'h0F, 1'b1, 8'h01}, {8'h0F, 1'b1, 8'h02}, {8'h0F, 1'b1, 8'h04},
    {8'h0F, 1'b1, 8'h08}, {8'h0F, 1'b1, 8'h01}, {8'h0A, 1'b1, 8'h02},
    {8'h0A, 1'b1, 8'h08}, {8'h30, 1'b1, 8'h20}, {8'h31, 1'b1, 8'h20},
    {8'h91, 1'b1, 8'h80}, {8'h0F, 1'b0, 8'h00}, {8'h00, 1'b1, 8'h00},
    {8'h05, 1'b1, 8'h01}, {8'h05, 1'b1, 8'h04}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R2 actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; ext_cnt = 3'd7; lp_cnt = 3'd3; sched_sel = 3'd0;
    vc_en = 8'hFF; vc_req = 8'h00; pkt_start = 1'b0;
    tbl_wr_en = 1'b0; tbl_wr_addr = '0; tbl_wr_data = '0; tbl_load = 1'b0;
    repeat (3) tick();
    rst = 1'b0;
    check("R1 gnt after reset", gnt, 0);
    check("R1 busy after reset", tbl_busy, 0);

    // vector walk: round robin, strict priority, start gating
    for (int i = 0; i < 14; i++) begin
      vc_req = VECS[i][16:9];
      pkt_start = VECS[i][8];
      tick();
      check($sformatf("R4 R3 R2 vector %0d", i), gnt, VECS[i][7:0]);
    end

    // nonexistent channel
    ext_cnt = 3'd2; vc_req = 8'h80; pkt_start = 1'b1;
    tick();
    check("R2 channel above ext_cnt", gnt, 0);
    ext_cnt = 3'd7; pkt_start = 1'b0; vc_req = 8'h00;

    // weighted 32 with one group channel enabled
    vc_en = 8'h01; sched_sel = 3'd1;
    tick();
    // pending: p<32 -> {1,2,15,0} by p%4 ; p>=32 -> 3
    for (int p = 0; p < 64; p++) begin
      tbl_wr_en = 1'b1; tbl_wr_addr = 6'(p);
      tbl_wr_data = (p >= 32) ? 4'd3 : ((p % 4 == 0) ? 4'd1 : (p % 4 == 1) ? 4'd2 :
                    (p % 4 == 2) ? 4'd15 : 4'd0);
      tick();
    end
    tbl_wr_en = 1'b0;

    vc_en = 8'h07; vc_req = 8'h07; pkt_start = 1'b1;
    tick(); check("R8 R1 pending not active", gnt, 8'h01);
    tick(); check("R8 R1 pending not active 2", gnt, 8'h01);

    pkt_start = 1'b0; tbl_load = 1'b1;
    tick(); tbl_load = 1'b0;
    check("R9 busy after load", tbl_busy, 1);
    repeat (64) tick();
    check("R9 busy still copying", tbl_busy, 1);
    tick();
    check("R9 busy done", tbl_busy, 0);

    pkt_start = 1'b1;
    tick(); check("R7 skip bad entry", gnt, 8'h01);
    tick(); check("R7 phase4", gnt, 8'h02);
    tick(); check("R7 phase5", gnt, 8'h04);
    tick(); check("R7 phase7", gnt, 8'h01);
    vc_req = 8'h05;
    tick(); check("R7 skip idle VC1", gnt, 8'h04);
    tick(); check("R7 skip idle VC1 b", gnt, 8'h01);
    tick(); check("R7 skip idle VC1 c", gnt, 8'h04);

    vc_en = 8'h0F; vc_req = 8'h08;
    tick(); check("R7 R5 wrap at 32 phases", gnt, 8'h00);

    sched_sel = 3'd2;
    tick(); tick();
    check("R6 select frozen", gnt, 8'h00);

    pkt_start = 1'b0; vc_en = 8'h01;
    tick();
    vc_en = 8'h0F; vc_req = 8'h08; pkt_start = 1'b1;
    tick(); check("R5 64 phase upper half", gnt, 8'h08);
    vc_req = 8'h01;
    tick(); check("R7 R5 wrap at 64 phases", gnt, 8'h01);

    pkt_start = 1'b0; sched_sel = 3'd3; vc_en = 8'h01;
    tick();
    vc_en = 8'h03; vc_req = 8'h03; pkt_start = 1'b1;
    tick(); check("R5 code3 round robin", gnt, 8'h01);
    tick(); check("R5 R4 code3 round robin b", gnt, 8'h02);

    // load restart during copy
    pkt_start = 1'b0; tbl_load = 1'b1;
    tick(); tbl_load = 1'b0;
    repeat (9) tick();
    tbl_load = 1'b1;
    tick(); tbl_load = 1'b0;
    repeat (64) tick();
    check("R9 restart keeps busy", tbl_busy, 1);
    tick();
    check("R9 restart done", tbl_busy, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule